// File: doc/BRIEF.md
# Multiplexed Bus Peripheral Port

This block is the slave side of a serial controller's host connection. An external processor reaches it over a 16-bit address/data bus with active-low chip enable, data strobe and address strobe and a read/write line. The bus lines arrive with no timing relation to the internal clock, so the strobes are passed through a synchroniser. The block then turns each bus cycle into a single read or write request on an internal register file port. On a read, the returned word is driven back onto the bus.

The first write after reset is taken by the block itself as the bus configuration write and does not reach the register file. Bit 0 of that write's data selects the address mode. In multiplexed mode the address comes from the shared lines while the address strobe is low. In non-multiplexed mode it comes from dedicated address pins and the address strobe is ignored. Address bit 1 of the same write selects the handshake style. With bit 1 set, the active-low handshake acts as a wait line. With bit 1 clear, it acts as a ready/acknowledge line. Whenever the device is bus master, it ignores chip enable and neither drives the bus nor asserts the handshake.

Top module: `mbus_slave_if`

## Requirements
- R1: After reset, ad_oe_o=0, hs_n_o=1, reg_wr_o=0, reg_rd_o=0, cfg_mux_o=1 (multiplexed) and cfg_wait_o=0 (ready style).
- R2: The first write after reset produces no reg_wr_o pulse. It sets cfg_mux_o to data bit 0 and cfg_wait_o to address bit 1. Later writes leave both unchanged.
- R3: A falling data strobe with chip enable low and rw_i=0 gives exactly one reg_wr_o pulse. The pulse carries the address and the ad_i word present at the strobe edge.
- R4: A falling data strobe with chip enable low and rw_i=1 gives exactly one reg_rd_o pulse. Once reg_rdy_i returns, ad_o carries reg_rdata_i and ad_oe_o stays high while data strobe and chip enable are low. ad_oe_o drops within 4 cycles after the data strobe rises.
- R5: With chip enable high, a strobe produces no register request and no bus drive.
- R6: While bus_master_i=1, strobes produce no request, ad_oe_o stays 0 and hs_n_o stays 1.
- R7: In multiplexed mode, the access address is ad_i[ADDR_W-1:0] as last seen while the address strobe was low.
- R8: In non-multiplexed mode, the access address is addr_i at the data strobe edge, and address strobe pulses have no effect.
- R9: In wait style, hs_n_o is low from strobe detection until read data is ready and then high. It stays high during writes.
- R10: In ready style, hs_n_o is high until the access is ready (read data returned, or a write accepted). It is then low, and it goes high again within 4 cycles after the data strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_master_i | input | 1 | Device currently owns the bus; slave port disabled |
| ce_n_i | input | 1 | Chip enable, active low, asynchronous |
| ds_n_i | input | 1 | Data strobe, active low, asynchronous |
| rw_i | input | 1 | 1 = read, 0 = write |
| as_n_i | input | 1 | Address strobe, active low (multiplexed mode only) |
| ad_i | input | DATA_W | Bus address/data lines, input side |
| addr_i | input | ADDR_W | Dedicated address pins (non-multiplexed mode) |
| ad_o | output | DATA_W | Read data for the bus |
| ad_oe_o | output | 1 | Bus driver enable |
| hs_n_o | output | 1 | Wait/ready handshake, active low |
| reg_wr_o | output | 1 | Register write request pulse |
| reg_rd_o | output | 1 | Register read request pulse |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_rdata_i | input | DATA_W | Register read data |
| reg_rdy_i | input | 1 | Read data valid |
| cfg_mux_o | output | 1 | 1 = multiplexed address mode |
| cfg_wait_o | output | 1 | 1 = wait-style handshake |

## Verification
A corrupted access state shows up at once on the handshake. It either sticks low, so a wait-style bus stalls, or it never asserts, so a ready-style bus times out. A wrong latched address or mode bit does not show at the point of failure. It surfaces at the next read-back, where ad_o carries the contents of another register. Every access is therefore checked against a bench-held register image. Handshake level is sampled four cycles after the strobe falls, and driver release is sampled four cycles after the strobe rises.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RDWAIT = 2'd1,
    ST_DONE   = 2'd2
  } acc_state_t;
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mbs_addr_sel.sv
module mbs_addr_sel #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mux_mode_i,
  input  logic              as_s_i,
  input  logic [ADDR_W-1:0] ad_lo_i,
  input  logic [ADDR_W-1:0] addr_pins_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] mux_addr_q;

  // follow the shared lines while the strobe is low; hold the last value
  always_ff @(posedge clk) begin
    if (rst)          mux_addr_q <= '0;
    else if (!as_s_i) mux_addr_q <= ad_lo_i;
  end

  assign addr_o = mux_mode_i ? mux_addr_q : addr_pins_i;
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 6,
  parameter int CFG_MUX_BIT   = 0,
  parameter int CFG_STYLE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ds_fall_i,
  input  logic              ds_s_i,
  input  logic              ce_s_i,
  input  logic              rw_s_i,
  input  logic              master_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_rdy_i,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              hs_n_o,
  output logic              cfg_done_o,
  output logic              cfg_mux_o,
  output logic              cfg_wait_o
);
  acc_state_t st_q, st_nxt;
  logic       is_rd_q;
  logic       sel;
  logic       start;
  logic       rd_cur;

  assign sel    = !ce_s_i && !master_i;
  assign start  = (st_q == ST_IDLE) && ds_fall_i && sel;
  assign rd_cur = (st_q == ST_IDLE) ? rw_s_i : is_rd_q;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE:   if (start) st_nxt = rw_s_i ? ST_RDWAIT : ST_DONE;
      ST_RDWAIT: begin
        if (ds_s_i)         st_nxt = ST_IDLE;
        else if (reg_rdy_i) st_nxt = ST_DONE;
      end
      ST_DONE:   if (ds_s_i) st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      is_rd_q     <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_rd_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      ad_o        <= '0;
      ad_oe_o     <= 1'b0;
      hs_n_o      <= 1'b1;
      cfg_done_o  <= 1'b0;
      cfg_mux_o   <= 1'b1;
      cfg_wait_o  <= 1'b0;
    end else begin
      st_q     <= st_nxt;
      reg_wr_o <= 1'b0;
      reg_rd_o <= 1'b0;
      if (start) begin
        is_rd_q <= rw_s_i;
        if (rw_s_i) begin
          reg_rd_o   <= 1'b1;
          reg_addr_o <= addr_i;
        end else if (!cfg_done_o) begin
          cfg_done_o <= 1'b1;
          cfg_mux_o  <= ad_i[CFG_MUX_BIT];
          cfg_wait_o <= addr_i[CFG_STYLE_BIT];
        end else begin
          reg_wr_o    <= 1'b1;
          reg_addr_o  <= addr_i;
          reg_wdata_o <= ad_i;
        end
      end
      if (st_q == ST_RDWAIT && !ds_s_i && reg_rdy_i) ad_o <= reg_rdata_i;
      ad_oe_o <= (st_nxt == ST_DONE) && rd_cur && sel;
      if (master_i)        hs_n_o <= 1'b1;
      else if (cfg_wait_o) hs_n_o <= (st_nxt != ST_RDWAIT);
      else                 hs_n_o <= (st_nxt != ST_DONE);
    end
  end
endmodule

// File: rtl/mbus_slave_if.sv
module mbus_slave_if #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_master_i,
  input  logic              ce_n_i,
  input  logic              ds_n_i,
  input  logic              rw_i,
  input  logic              as_n_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              hs_n_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_rdy_i,
  output logic              cfg_mux_o,
  output logic              cfg_wait_o
);
  localparam int NSIG = 4;

  logic [NSIG-1:0]   raw, synced;
  logic              ce_s, ds_s, rw_s, as_s;
  logic              ds_prev_q;
  logic              ds_fall;
  logic [ADDR_W-1:0] acc_addr;
  logic              cfg_done;

  assign raw = {ce_n_i, ds_n_i, rw_i, as_n_i};

  mbs_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL({NSIG{1'b1}})) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (synced)
  );

  assign {ce_s, ds_s, rw_s, as_s} = synced;

  always_ff @(posedge clk) begin
    if (rst) ds_prev_q <= 1'b1;
    else     ds_prev_q <= ds_s;
  end
  assign ds_fall = ds_prev_q && !ds_s;

  mbs_addr_sel #(.ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .mux_mode_i  (cfg_mux_o),
    .as_s_i      (as_s),
    .ad_lo_i     (ad_i[ADDR_W-1:0]),
    .addr_pins_i (addr_i),
    .addr_o      (acc_addr)
  );

  mbs_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ds_fall_i   (ds_fall),
    .ds_s_i      (ds_s),
    .ce_s_i      (ce_s),
    .rw_s_i      (rw_s),
    .master_i    (bus_master_i),
    .addr_i      (acc_addr),
    .ad_i        (ad_i),
    .reg_rdata_i (reg_rdata_i),
    .reg_rdy_i   (reg_rdy_i),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .hs_n_o      (hs_n_o),
    .cfg_done_o  (cfg_done),
    .cfg_mux_o   (cfg_mux_o),
    .cfg_wait_o  (cfg_wait_o)
  );
endmodule

// File: rtl/mbus_slave_if_chk.sv
module mbus_slave_if_chk (
  input logic clk,
  input logic rst,
  input logic bus_master_i,
  input logic reg_wr_o,
  input logic reg_rd_o,
  input logic ad_oe_o,
  input logic hs_n_o,
  input logic cfg_mux_o,
  input logic cfg_wait_o,
  input logic cfg_done
);
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_o && reg_rd_o)); // R3
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o); // R3
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_rd_o |=> !reg_rd_o); // R4
  AST_MASTER_QUIET: assert property (@(posedge clk) disable iff (rst)
    bus_master_i |=> (!ad_oe_o && hs_n_o)); // R6
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_done) |-> ($stable(cfg_mux_o) && $stable(cfg_wait_o))); // R2
  AST_WAIT_WR_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cfg_wait_o && reg_wr_o) |-> hs_n_o); // R9
endmodule

bind mbus_slave_if mbus_slave_if_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_master_i (bus_master_i),
  .reg_wr_o     (reg_wr_o),
  .reg_rd_o     (reg_rd_o),
  .ad_oe_o      (ad_oe_o),
  .hs_n_o       (hs_n_o),
  .cfg_mux_o    (cfg_mux_o),
  .cfg_wait_o   (cfg_wait_o),
  .cfg_done     (cfg_done)
);

// File: tb/mbus_slave_if_test.sv
module mbus_slave_if_test;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_master_i = 1'b0;
  logic          ce_n_i = 1'b1, ds_n_i = 1'b1, rw_i = 1'b1, as_n_i = 1'b1;
  logic [DW-1:0] ad_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] ad_o, reg_wdata_o, reg_rdata_i;
  logic          ad_oe_o, hs_n_o, reg_wr_o, reg_rd_o, reg_rdy_i;
  logic [AW-1:0] reg_addr_o;
  logic          cfg_mux_o, cfg_wait_o;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  bit mux_m = 1'b1;
  bit wait_m = 1'b0;
  logic [DW-1:0] expv [DEPTH];

  always #5 clk = ~clk;

  mbus_slave_if uut (
    .clk(clk), .rst(rst), .bus_master_i(bus_master_i),
    .ce_n_i(ce_n_i), .ds_n_i(ds_n_i), .rw_i(rw_i), .as_n_i(as_n_i),
    .ad_i(ad_i), .addr_i(addr_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .hs_n_o(hs_n_o), .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i), .reg_rdy_i(reg_rdy_i),
    .cfg_mux_o(cfg_mux_o), .cfg_wait_o(cfg_wait_o)
  );

  function automatic logic [DW-1:0] init_val(input int i);
    return 16'hA500 ^ (16'(i) * 16'h0101);
  endfunction

  // register file model
  logic [DW-1:0] mem [DEPTH];
  logic          pend;
  int            rdcnt;
  logic [AW-1:0] raddr;
  int            wr_seen;
  int            rd_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
      pend <= 1'b0; rdcnt <= 0; raddr <= '0; reg_rdy_i <= 1'b0;
      reg_rdata_i <= '0; wr_seen <= 0; rd_seen <= 0;
    end else begin
      reg_rdy_i <= 1'b0;
      if (reg_wr_o) begin
        mem[reg_addr_o] <= reg_wdata_o;
        wr_seen <= wr_seen + 1;
      end
      if (reg_rd_o) begin
        pend <= 1'b1; rdcnt <= lat; raddr <= reg_addr_o;
        rd_seen <= rd_seen + 1;
      end else if (pend) begin
        if (rdcnt == 0) begin
          reg_rdy_i <= 1'b1; reg_rdata_i <= mem[raddr]; pend <= 1'b0;
        end else rdcnt <= rdcnt - 1;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    rst = 1'b1; ce_n_i = 1'b1; ds_n_i = 1'b1; rw_i = 1'b1; as_n_i = 1'b1;
    bus_master_i = 1'b0; mux_m = 1'b1; wait_m = 1'b0;
    for (int i = 0; i < DEPTH; i++) expv[i] = init_val(i);
    cyc(4); rst = 1'b0; cyc(2);
  endtask

  // address phase; in non-multiplexed mode a decoy address strobe is pulsed (R8)
  task automatic addr_phase(input logic [AW-1:0] a);
    if (mux_m) begin
      as_n_i = 1'b0; ad_i = {{(DW-AW){1'b0}}, a ^ 6'h15}; cyc(2);
      ad_i = {{(DW-AW){1'b0}}, a}; cyc(3);
      as_n_i = 1'b1; cyc(3);
    end else begin
      addr_i = a; as_n_i = 1'b0; ad_i = {{(DW-AW){1'b0}}, ~a}; cyc(2);
      as_n_i = 1'b1; cyc(3);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit ce_on, input bit apply, input bit hs_chk);
    addr_phase(a);
    ad_i = d; rw_i = 1'b0; ce_n_i = !ce_on; ds_n_i = 1'b0; cyc(4);
    if (hs_chk) begin
      if (wait_m) check(hs_n_o == 1'b1, "R9 write handshake", 32'(hs_n_o), 32'd1);
      else        check(hs_n_o == 1'b0, "R10 write handshake", 32'(hs_n_o), 32'd0);
    end
    cyc(2); ds_n_i = 1'b1; cyc(1); ce_n_i = 1'b1; rw_i = 1'b1; cyc(4);
    if (apply) expv[a] = d;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input bit ce_on,
                          output bit drove, output logic [DW-1:0] val);
    drove = 1'b0; val = '0;
    addr_phase(a);
    ad_i = '0; rw_i = 1'b1; ce_n_i = !ce_on; ds_n_i = 1'b0; cyc(4);
    if (ce_on && !bus_master_i) begin
      if (wait_m) check(hs_n_o == 1'b0, "R9 wait asserted", 32'(hs_n_o), 32'd0);
      else        check(hs_n_o == 1'b1, "R10 ready not yet", 32'(hs_n_o), 32'd1);
    end
    for (int k = 0; k < 30; k++) begin
      if (ad_oe_o) begin drove = 1'b1; val = ad_o; break; end
      cyc(1);
    end
    if (drove) begin
      if (wait_m) check(hs_n_o == 1'b1, "R9 wait released", 32'(hs_n_o), 32'd1);
      else        check(hs_n_o == 1'b0, "R10 ready asserted", 32'(hs_n_o), 32'd0);
    end
    ds_n_i = 1'b1; cyc(4);
    check(ad_oe_o == 1'b0, "R4 drive released", 32'(ad_oe_o), 32'd0);
    check(hs_n_o == 1'b1, "R10 handshake idle", 32'(hs_n_o), 32'd1);
    ce_n_i = 1'b1; cyc(3);
  endtask

  task automatic read_check(input logic [AW-1:0] a, input string tag);
    bit drove; logic [DW-1:0] v;
    bus_read(a, 1'b1, drove, v);
    check(drove, {tag, " drive"}, 32'(drove), 32'd1);
    check(v == expv[a], {tag, " data"}, 32'(v), 32'(expv[a]));
  endtask

  task automatic random_ops(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int w0;
      a = AW'($urandom_range(0, DEPTH - 1));
      d = DW'($urandom);
      lat = $urandom_range(0, 5);
      if ($urandom_range(0, 1) == 1) begin
        w0 = wr_seen;
        bus_write(a, d, 1'b1, 1'b1, 1'b1);
        check(wr_seen == w0 + 1, {tag, " R3 one write"}, 32'(wr_seen), 32'(w0 + 1));
      end else begin
        read_check(a, {tag, " R4 read"});
      end
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    bit drove;
    logic [DW-1:0] v;
    int w0, r0;
    void'($urandom(32'd20240611));

    // Phase A: multiplexed, wait style
    do_reset();
    check(ad_oe_o == 0 && hs_n_o == 1 && reg_wr_o == 0 && reg_rd_o == 0,
          "R1 outputs idle", {ad_oe_o, hs_n_o, reg_wr_o, reg_rd_o}, 32'b0100);
    check(cfg_mux_o == 1 && cfg_wait_o == 0, "R1 cfg default",
          {cfg_mux_o, cfg_wait_o}, 32'b10);
    w0 = wr_seen;
    bus_write(6'h02, 16'h0001, 1'b1, 1'b0, 1'b0);
    mux_m = 1'b1; wait_m = 1'b1;
    check(cfg_mux_o == 1 && cfg_wait_o == 1, "R2 config taken",
          {cfg_mux_o, cfg_wait_o}, 32'b11);
    check(wr_seen == w0, "R2 config not forwarded", 32'(wr_seen), 32'(w0));

    // R7 address latch: decoy value early in AS low, final value kept
    lat = 2;
    bus_write(6'h2A, 16'hBEEF, 1'b1, 1'b1, 1'b1);
    read_check(6'h2A, "R7 mux address");
    read_check(6'h3F, "R7 mux address untouched");

    random_ops(20, "phaseA");

    // R2 later write with A1 high and data bit0 low leaves config
    bus_write(6'h06, 16'h0000, 1'b1, 1'b1, 1'b1);
    check(cfg_mux_o == 1 && cfg_wait_o == 1, "R2 config held",
          {cfg_mux_o, cfg_wait_o}, 32'b11);

    // R5 chip enable high
    w0 = wr_seen; r0 = rd_seen;
    bus_write(6'h2A, 16'h1111, 1'b0, 1'b0, 1'b0);
    check(wr_seen == w0, "R5 no write", 32'(wr_seen), 32'(w0));
    bus_read(6'h2A, 1'b0, drove, v);
    check(!drove, "R5 no drive", 32'(drove), 32'd0);
    check(rd_seen == r0, "R5 no read", 32'(rd_seen), 32'(r0));
    read_check(6'h2A, "R5 data unchanged");

    // R6 bus master
    bus_master_i = 1'b1;
    w0 = wr_seen; r0 = rd_seen;
    bus_write(6'h2A, 16'h2222, 1'b1, 1'b0, 1'b0);
    check(wr_seen == w0, "R6 no write", 32'(wr_seen), 32'(w0));
    ad_i = '0; rw_i = 1'b1; ce_n_i = 1'b0; ds_n_i = 1'b0; cyc(5);
    check(hs_n_o == 1'b1, "R6 handshake high", 32'(hs_n_o), 32'd1);
    check(ad_oe_o == 1'b0, "R6 no drive", 32'(ad_oe_o), 32'd0);
    ds_n_i = 1'b1; ce_n_i = 1'b1; cyc(4);
    check(rd_seen == r0, "R6 no read", 32'(rd_seen), 32'(r0));
    bus_master_i = 1'b0; cyc(2);
    read_check(6'h2A, "R6 data unchanged");

    // Phase B: non-multiplexed, ready style
    do_reset();
    bus_write(6'h01, 16'hFFFE, 1'b1, 1'b0, 1'b0);
    mux_m = 1'b0; wait_m = 1'b0;
    check(cfg_mux_o == 0 && cfg_wait_o == 0, "R2 config nonmux ready",
          {cfg_mux_o, cfg_wait_o}, 32'b00);
    lat = 0;
    bus_write(6'h15, 16'hC0DE, 1'b1, 1'b1, 1'b1);
    read_check(6'h15, "R8 pin address");
    read_check(6'h2A, "R8 strobe ignored");
    random_ops(20, "phaseB");

    finish_sim();
  end
endmodule